// File: doc/BRIEF.md
# Serial Memory Timing Parameter Calculator

This block turns a system clock frequency and the highest clock rate a quad serial memory accepts into the timing fields its interface controller needs. Those fields are the serial clock divisor, the receive sampling delay, the longest allowed chip-select window (counted in units of 64 system clocks) and the shortest gap between selects (counted in system clocks). A fixed cooldown count and a page-boundary size are also presented.

A one-cycle `start_i` pulse captures both frequencies. A single restoring divider, which yields one quotient bit per cycle, then works through five divisions in a fixed order: ceiling divisor, rate check, clock period in femtoseconds, select window, deselect gap. When the last division is done, all fields update together and `valid_o` pulses for one cycle. Frequencies are given in hertz and must be nonzero. The usual maximum serial clock is 109 MHz.

Top module: `sm_timing_calc`

## Requirements
- R1: `clkdiv_o` is the ceiling of `sys_hz_i / max_sck_hz_i` (after the R2 rule) and clamps to 255.
- R2: When that ceiling is 1 and `sys_hz_i` is above 100,000,000, the divisor becomes 2.
- R3: `rxdelay_o` equals the R2 divisor, plus 1 when `floor(sys_hz_i / divisor)` is above 100,000,000. The sum clamps to 15.
- R4: With `period = floor(10^15 / sys_hz_i)`, `max_select_o` is `floor(125,000,000 / period)` and clamps to 63.
- R5: `min_deselect_o` is `ceil(18,000,000 / period) - ceil(divisor / 2)`, using the unclamped R2 divisor. It is 0 when that difference is zero or negative, and it clamps to 31.
- R6: `cooldown_o` is always 1 and `page_log2_o` is always 10, which means a 1024-byte page boundary.
- R7: `busy_o` is high from the edge that samples `start_i` until the result edge. Exactly 261 rising edges after the sampling edge, `valid_o` is high for one cycle while `busy_o` is low.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The result and its latency come from the first capture.
- R9: While reset is asserted, and after it, `busy_o`, `valid_o` and all four computed fields are 0.
- R10: The computed fields change only on the cycle `valid_o` is high. Otherwise they hold their last values, even if the frequency inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin computation |
| sys_hz_i | input | FREQ_W | System clock frequency in Hz |
| max_sck_hz_i | input | FREQ_W | Highest allowed serial clock frequency in Hz |
| busy_o | output | 1 | Computation in progress |
| valid_o | output | 1 | One-cycle result strobe |
| clkdiv_o | output | DIV_W | Serial clock divisor |
| rxdelay_o | output | RXD_W | Receive sampling delay |
| max_select_o | output | SEL_W | Longest select window, units of 64 clocks |
| min_deselect_o | output | DES_W | Shortest deselect gap, in clocks |
| cooldown_o | output | 2 | Fixed cooldown count |
| page_log2_o | output | 4 | Log2 of page boundary size in bytes |

## Verification
Every division takes 52 edges: one issue cycle, 50 iterations, and one capture edge. Five divisions plus one output register put all four fields 261 edges after the edge that samples `start_i`. The bench drives on falling edges and counts falling edges from the sampling edge. It requires `valid_o` exactly at that count and `busy_o` high on every earlier sample, and it reads the fields in the same half-cycle as the strobe. Later samples, taken while the inputs are disturbed or a second start is pulsed, show that nothing moves outside that cycle.

// File: rtl/sm_timing_pkg.sv
`timescale 1ns/1ps
package sm_timing_pkg;
  localparam int NUM_W = 50;
  localparam logic [NUM_W-1:0] FS_PER_SEC  = NUM_W'(64'd1_000_000_000_000_000);
  localparam logic [NUM_W-1:0] HI_RATE_HZ  = NUM_W'(64'd100_000_000);
  localparam logic [NUM_W-1:0] SEL_WIN_NUM = NUM_W'(64'd125_000_000);
  localparam logic [NUM_W-1:0] DESEL_NUM   = NUM_W'(64'd18_000_000);
  localparam logic [1:0]       COOLDOWN    = 2'd1;
  localparam logic [3:0]       PAGE_LOG2   = 4'd10;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} calc_st_e;
  typedef enum logic [2:0] {OP_CEIL_DIV, OP_RATE_CHK, OP_PERIOD, OP_SEL_WIN, OP_DESEL} calc_op_e;
endpackage

// File: rtl/sm_iter_div.sv
`timescale 1ns/1ps
module sm_iter_div #(
  parameter int W = 50
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [W:0]    trial;

  assign trial = {rem_q, quo_q[W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (go_i) begin
      rem_q <= '0;
      quo_q <= num_i;
      den_q <= den_i;
      cnt_q <= CW'(W);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q != '0) begin
        if (trial >= {1'b0, den_q}) begin
          rem_q <= W'(trial - {1'b0, den_q});
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  assign done_o = act_q && (cnt_q == '0);
  assign quo_o  = quo_q;
endmodule

// File: rtl/sm_sat_field.sv
`timescale 1ns/1ps
module sm_sat_field #(
  parameter int IN_W  = 50,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  assign val_o = (|val_i[IN_W-1:OUT_W]) ? '1 : val_i[OUT_W-1:0];
endmodule

// File: rtl/sm_timing_calc.sv
`timescale 1ns/1ps
module sm_timing_calc
  import sm_timing_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int DIV_W  = 8,
  parameter int RXD_W  = 4,
  parameter int SEL_W  = 6,
  parameter int DES_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] sys_hz_i,
  input  logic [FREQ_W-1:0] max_sck_hz_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DIV_W-1:0]  clkdiv_o,
  output logic [RXD_W-1:0]  rxdelay_o,
  output logic [SEL_W-1:0]  max_select_o,
  output logic [DES_W-1:0]  min_deselect_o,
  output logic [1:0]        cooldown_o,
  output logic [3:0]        page_log2_o
);
  calc_st_e          st_q;
  calc_op_e          op_q;
  logic [NUM_W-1:0]  sys_q, max_q;
  logic [NUM_W-1:0]  div_q, rx_q, per_q, sel_q, dsc_q;
  logic [NUM_W-1:0]  num, den, quo, half_div, des_full;
  logic              div_go, div_done;
  logic [DIV_W-1:0]  div_sat;
  logic [RXD_W-1:0]  rx_sat;
  logic [SEL_W-1:0]  sel_sat;
  logic [DES_W-1:0]  des_sat;
  logic              valid_q;
  logic [DIV_W-1:0]  clkdiv_q;
  logic [RXD_W-1:0]  rxdelay_q;
  logic [SEL_W-1:0]  sel_out_q;
  logic [DES_W-1:0]  des_out_q;

  always_comb begin
    num = '0;
    den = '0;
    unique case (op_q)
      OP_CEIL_DIV: begin num = sys_q + max_q - NUM_W'(1); den = max_q; end
      OP_RATE_CHK: begin num = sys_q;                      den = div_q; end
      OP_PERIOD:   begin num = FS_PER_SEC;                 den = sys_q; end
      OP_SEL_WIN:  begin num = SEL_WIN_NUM;                den = per_q; end
      OP_DESEL:    begin num = DESEL_NUM + per_q - NUM_W'(1); den = per_q; end
      default:     begin num = '0; den = '0; end
    endcase
  end

  assign div_go = (st_q == ST_ISSUE);

  sm_iter_div #(.W(NUM_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go),
    .num_i  (num),
    .den_i  (den),
    .done_o (div_done),
    .quo_o  (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_CEIL_DIV;
      sys_q <= '0;
      max_q <= '0;
      div_q <= '0;
      rx_q  <= '0;
      per_q <= '0;
      sel_q <= '0;
      dsc_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          sys_q <= NUM_W'(sys_hz_i);
          max_q <= NUM_W'(max_sck_hz_i);
          op_q  <= OP_CEIL_DIV;
          st_q  <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          unique case (op_q)
            // unity divisor is unsafe above the high-rate threshold
            OP_CEIL_DIV: div_q <= (quo == NUM_W'(1) && sys_q > HI_RATE_HZ) ? NUM_W'(2) : quo;
            OP_RATE_CHK: rx_q  <= div_q + NUM_W'(quo > HI_RATE_HZ);
            OP_PERIOD:   per_q <= quo;
            OP_SEL_WIN:  sel_q <= quo;
            OP_DESEL:    dsc_q <= quo;
            default:     ;
          endcase
          if (op_q == OP_DESEL) st_q <= ST_FIN;
          else begin
            op_q <= calc_op_e'(op_q + 3'd1);
            st_q <= ST_ISSUE;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign half_div = (div_q + NUM_W'(1)) >> 1;
  assign des_full = (dsc_q > half_div) ? dsc_q - half_div : '0;

  sm_sat_field #(.IN_W(NUM_W), .OUT_W(DIV_W)) u_sat_div (.val_i(div_q),    .val_o(div_sat));
  sm_sat_field #(.IN_W(NUM_W), .OUT_W(RXD_W)) u_sat_rx  (.val_i(rx_q),     .val_o(rx_sat));
  sm_sat_field #(.IN_W(NUM_W), .OUT_W(SEL_W)) u_sat_sel (.val_i(sel_q),    .val_o(sel_sat));
  sm_sat_field #(.IN_W(NUM_W), .OUT_W(DES_W)) u_sat_des (.val_i(des_full), .val_o(des_sat));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      clkdiv_q  <= '0;
      rxdelay_q <= '0;
      sel_out_q <= '0;
      des_out_q <= '0;
    end else begin
      valid_q <= (st_q == ST_FIN);
      if (st_q == ST_FIN) begin
        clkdiv_q  <= div_sat;
        rxdelay_q <= rx_sat;
        sel_out_q <= sel_sat;
        des_out_q <= des_sat;
      end
    end
  end

  assign busy_o         = (st_q != ST_IDLE);
  assign valid_o        = valid_q;
  assign clkdiv_o       = clkdiv_q;
  assign rxdelay_o      = rxdelay_q;
  assign max_select_o   = sel_out_q;
  assign min_deselect_o = des_out_q;
  assign cooldown_o     = COOLDOWN;
  assign page_log2_o    = PAGE_LOG2;
endmodule

// File: rtl/sm_timing_calc_chk.sv
`timescale 1ns/1ps
module sm_timing_calc_chk #(
  parameter int DIV_W = 8,
  parameter int RXD_W = 4,
  parameter int SEL_W = 6,
  parameter int DES_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             valid_o,
  input logic [DIV_W-1:0] clkdiv_o,
  input logic [RXD_W-1:0] rxdelay_o,
  input logic [SEL_W-1:0] max_select_o,
  input logic [DES_W-1:0] min_deselect_o
);
  // R7
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R7
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  valid_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || valid_o));

  // R10
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(clkdiv_o) && $stable(rxdelay_o) &&
                  $stable(max_select_o) && $stable(min_deselect_o)));

  // R3
  rx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((DIV_W+1)'(rxdelay_o) <= (DIV_W+1)'(clkdiv_o) + (DIV_W+1)'(1)));
endmodule

bind sm_timing_calc sm_timing_calc_chk #(
  .DIV_W(DIV_W), .RXD_W(RXD_W), .SEL_W(SEL_W), .DES_W(DES_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .busy_o         (busy_o),
  .valid_o        (valid_o),
  .clkdiv_o       (clkdiv_o),
  .rxdelay_o      (rxdelay_o),
  .max_select_o   (max_select_o),
  .min_deselect_o (min_deselect_o)
);

// File: tb/tb_sm_timing_calc.sv
`timescale 1ns/1ps
module tb_sm_timing_calc;
  localparam int LAT = 261;
  localparam int NV  = 13;

  localparam logic [31:0] V_SYS [NV] = '{
    32'd150_000_000, 32'd125_000_000, 32'd100_000_000, 32'd109_000_000,
    32'd300_000_000, 32'd250_000_000, 32'd210_000_000, 32'd600_000_000,
    32'd100_000_000, 32'd2_000_000_000, 32'd200_000_002, 32'd4_000_000_000,
    32'd20_000_000};
  localparam logic [31:0] V_MAX [NV] = '{
    32'd109_000_000, 32'd109_000_000, 32'd109_000_000, 32'd109_000_000,
    32'd109_000_000, 32'd109_000_000, 32'd109_000_000, 32'd109_000_000,
    32'd10_000_000,  32'd109_000_000, 32'd109_000_000, 32'd1_000_000,
    32'd109_000_000};
  localparam int V_DIV [NV] = '{2, 2, 1, 2, 3, 3, 2, 6, 10, 19, 2, 255, 1};
  localparam int V_RX  [NV] = '{2, 2, 1, 2, 3, 3, 3, 6, 10, 15, 3, 15, 1};
  localparam int V_SEL [NV] = '{18, 15, 12, 13, 37, 31, 26, 63, 12, 63, 25, 63, 2};
  localparam int V_DES [NV] = '{2, 2, 1, 1, 4, 3, 3, 8, 0, 26, 3, 0, 0};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] sys_hz_i = '0;
  logic [31:0] max_sck_hz_i = '0;
  logic        busy_o, valid_o;
  logic [7:0]  clkdiv_o;
  logic [3:0]  rxdelay_o;
  logic [5:0]  max_select_o;
  logic [4:0]  min_deselect_o;
  logic [1:0]  cooldown_o;
  logic [3:0]  page_log2_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sm_timing_calc dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .sys_hz_i(sys_hz_i), .max_sck_hz_i(max_sck_hz_i),
    .busy_o(busy_o), .valid_o(valid_o),
    .clkdiv_o(clkdiv_o), .rxdelay_o(rxdelay_o),
    .max_select_o(max_select_o), .min_deselect_o(min_deselect_o),
    .cooldown_o(cooldown_o), .page_log2_o(page_log2_o)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // Pulse start, optionally pulse a second start mid-run; return latency and busy status
  task automatic run_calc(input logic [31:0] s, input logic [31:0] m, input bit poke,
                          output int lat, output bit busy_ok);
    int cnt;
    @(negedge clk);
    sys_hz_i = s; max_sck_hz_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 1;
    busy_ok = 1'b1;
    while (!valid_o && cnt < 400) begin
      if (!busy_o) busy_ok = 1'b0;
      if (poke && cnt == 100) begin
        sys_hz_i = 32'd600_000_000; max_sck_hz_i = 32'd10_000_000; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
    lat = cnt - 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int lat;
    bit bok;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", busy_o, 0);
    chk("R9 valid in reset", valid_o, 0);
    chk("R9 clkdiv in reset", clkdiv_o, 0);
    chk("R9 deselect in reset", min_deselect_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 busy after reset", busy_o, 0);
    chk("R9 select after reset", max_select_o, 0);

    for (int i = 0; i < NV; i++) begin
      run_calc(V_SYS[i], V_MAX[i], 1'b0, lat, bok);
      chk("R7 latency", lat, LAT);
      chk("R7 busy during run", bok, 1);
      chk("R7 busy low at valid", busy_o, 0);
      chk("R1 R2 clkdiv", clkdiv_o, V_DIV[i]);
      chk("R3 rxdelay", rxdelay_o, V_RX[i]);
      chk("R4 max select", max_select_o, V_SEL[i]);
      chk("R5 min deselect", min_deselect_o, V_DES[i]);
      chk("R6 cooldown", cooldown_o, 1);
      chk("R6 page log2", page_log2_o, 10);
    end

    // R10: fields hold while inputs wander without start
    sys_hz_i = 32'd900_000_000; max_sck_hz_i = 32'd5_000_000;
    repeat (30) @(negedge clk);
    chk("R10 valid stays low", valid_o, 0);
    chk("R10 clkdiv held", clkdiv_o, V_DIV[NV-1]);
    chk("R10 select held", max_select_o, V_SEL[NV-1]);
    chk("R10 deselect held", min_deselect_o, V_DES[NV-1]);

    // R8: second start mid-run is ignored
    run_calc(32'd300_000_000, 32'd109_000_000, 1'b1, lat, bok);
    chk("R8 latency unchanged", lat, LAT);
    chk("R8 clkdiv from first", clkdiv_o, 3);
    chk("R8 select from first", max_select_o, 37);
    chk("R8 deselect from first", min_deselect_o, 4);
    repeat (300) @(negedge clk);
    chk("R8 no second result", valid_o, 0);
    chk("R8 idle afterwards", busy_o, 0);
    chk("R8 clkdiv still first", clkdiv_o, 3);

    // R9: reset mid-run clears state
    @(negedge clk);
    sys_hz_i = 32'd150_000_000; max_sck_hz_i = 32'd109_000_000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (50) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R9 busy cleared", busy_o, 0);
    chk("R9 clkdiv cleared", clkdiv_o, 0);
    chk("R9 rxdelay cleared", rxdelay_o, 0);
    rst_ni = 1'b1;
    repeat (300) @(negedge clk);
    chk("R9 no stale result", valid_o, 0);
    chk("R9 fields remain zero", max_select_o, 0);

    summary();
    $finish;
  end
endmodule